// File: doc/BRIEF.md
# High-Side Switch Diagnostic Controller

This block is the digital core of a single-channel protected high-side load switch. It turns a control request into a gate enable for the power stage. It watches digital flags from the analog comparators: supply undervoltage, junction temperature against three thresholds, low load current and high output voltage. From these it drives an open-drain status line that is active low. The power stage, current limiting, clamps and comparators sit outside the block.

The status line reports a fault according to a truth table that depends on the control level. Each fault class has its own qualification delay, counted in clock cycles. Each delay timer starts again from zero whenever its condition drops before expiry, so short glitches are never reported. A thermal state machine turns the output off when the junction gets too hot. It restarts the output on a cooler threshold, keeps cycling while the overload lasts, and releases the status only on a third, lower threshold. The control and status-disable inputs are asynchronous and each passes through a two-flop synchronizer. The comparator flags are assumed to be synchronous to `clk`.

Top module: `hss_diag_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `gate_en` is 0, `stat_pd_en` is 0 (status released) and `stat_oe` is 1.
- R2: With no fault present, `gate_en` follows `ctl_in` two clock edges after it changes, and `stat_pd_en` stays 0 for both control levels.
- R3: `stat_oe` equals the inverse of `sdis_in` two clock edges after `sdis_in` changes. While `stat_oe` is 0 (status high impedance), `stat_pd_en` is 0 whatever the fault state.
- R4: When `gate_en` is 1 and `iload_low` is 1 for OLON_DLY consecutive cycles, `stat_pd_en` becomes 1 one cycle after the timer expires. A shorter run clears the timer and reports nothing.
- R5: After an on-state open load has been reported, the synchronized control going low keeps `stat_pd_en` at 1 for OLREL_DLY more cycles. It then returns to 0.
- R6: With synchronized control low, `vout_high` held for STK_DLY consecutive cycles sets `stat_pd_en` to 1. It clears one cycle after `vout_high` drops. With control high, `vout_high` is never reported.
- R7: `hot_flag` forces `gate_en` to 0 one cycle later. If `hot_flag` is held for OT_DLY cycles, an overtemperature flag is set one cycle after that. This flag pulls status low only while the synchronized control is 1.
- R8: After a shutdown, `cool_flag` with `hot_flag` low lets `gate_en` follow control again one cycle later. A new `hot_flag` turns the output off again. The overtemperature status stays asserted through this cycling.
- R9: The overtemperature status is cleared, one cycle later, only when `cold_flag` is seen after a restart.
- R10: `uv_flag` forces `gate_en` to 0 and `stat_pd_en` to 0 in the same cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_in | input | 1 | Asynchronous switch-on request |
| sdis_in | input | 1 | Asynchronous status disable (1 = status high impedance) |
| uv_flag | input | 1 | Supply below undervoltage threshold |
| hot_flag | input | 1 | Junction above shutdown temperature |
| cool_flag | input | 1 | Junction below restart temperature |
| cold_flag | input | 1 | Junction below status-clear temperature |
| iload_low | input | 1 | Load current below open-load threshold |
| vout_high | input | 1 | Output voltage above off-state open-load threshold |
| gate_en | output | 1 | Power stage enable |
| stat_pd_en | output | 1 | 1 = pull status line low (fault) |
| stat_oe | output | 1 | 0 = status line high impedance |

## Verification
The bench targets the exact expiry cycle of each delay. It checks one cycle before and at expiry, so a timer that counts one too many or too few cycles is caught. An open-load glitch one cycle shorter than the delay must leave no report and no leftover count. A timer that does not restart would report the next genuine fault early. The bench also checks that a release delay which drops the status at once is caught, and so is overtemperature status reported while control is low. During thermal cycling it looks for a status that clears at the restart threshold instead of the lower clear threshold. Finally it confirms that status disable hides an active stuck-output fault.

// File: rtl/hss_pkg.sv
`timescale 1ns/1ps
// Shared types for the high-side switch diagnostic controller.
package hss_pkg;
    // Thermal protection states: normal, forced off, restarted but still flagged.
    typedef enum logic [1:0] {
        TH_NORM = 2'd0,
        TH_OFF  = 2'd1,
        TH_RUN  = 2'd2
    } th_state_t;
endpackage

// File: rtl/hss_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for W asynchronous level signals.
// Assumes inputs are levels that are held far longer than two clock periods.
module hss_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture then re-register; reset both stages to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hss_qual_timer.sv
`timescale 1ns/1ps
// Qualification timer: done rises after cond has been sampled high on DLY
// consecutive edges, stays high while cond holds, and clears on the edge
// after cond drops. Assumes DLY >= 1.
module hss_qual_timer #(
    parameter int DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic done
);
    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(DLY));

    // Count consecutive qualified cycles, saturate at DLY, restart on a drop.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!cond)  cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end

    // R4 (also R6): done can only rise after a qualified cycle.
    p_rise_needs_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cond));

    // R6: a dropped condition clears the report on the next edge.
    p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> !done);
endmodule

// File: rtl/hss_thermal.sv
`timescale 1ns/1ps
// Thermal shutdown / auto-restart state machine with a qualified
// overtemperature status flag. Assumes the comparator flags are synchronous.
// hot has priority over cool and cold when flags overlap.
module hss_thermal #(
    parameter int OT_DLY = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic cool,
    input  logic cold,
    output logic force_off,
    output logic ot_flag
);
    import hss_pkg::*;

    th_state_t st, nxt;
    logic      ot_done;

    hss_qual_timer #(.DLY(OT_DLY)) u_ot_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (hot),
        .done (ot_done)
    );

    // Next thermal state: shut down on hot, restart on cool, settle on cold.
    always_comb begin
        nxt = st;
        unique case (st)
            TH_NORM: if (hot) nxt = TH_OFF;
            TH_OFF:  if (!hot && cool) nxt = TH_RUN;
            TH_RUN: begin
                if (hot)       nxt = TH_OFF;
                else if (cold) nxt = TH_NORM;
            end
            default: nxt = TH_NORM;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= TH_NORM;
        else        st <= nxt;
    end

    // Overtemperature status: set on qualified hot, clear only on cold after restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                                ot_flag <= 1'b0;
        else if (ot_done)                          ot_flag <= 1'b1;
        else if (st == TH_RUN && cold && !hot)     ot_flag <= 1'b0;
    end

    assign force_off = (st == TH_OFF);

    // R7: hot shuts the output down on the next edge.
    p_hot_forces_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> (st == TH_OFF));

    // R8: cooling after shutdown restarts the output.
    p_cool_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TH_OFF && cool && !hot) |=> (st == TH_RUN));

    // R9: the overtemperature status clears only after cold was seen.
    p_clear_on_cold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ot_flag) |-> $past(cold));
endmodule

// File: rtl/hss_diag_ctrl.sv
`timescale 1ns/1ps
// Digital control and diagnostic core of a single-channel high-side switch.
// Synchronizes the control and status-disable inputs, runs thermal
// protection, qualifies open-load and stuck-output faults with their own
// delays and maps them onto an active-low open-drain status line.
// Assumes comparator flags are synchronous to clk; all delays in cycles.
module hss_diag_ctrl #(
    parameter int OLON_DLY  = 20000,
    parameter int OLREL_DLY = 20000,
    parameter int STK_DLY   = 50000,
    parameter int OT_DLY    = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_in,
    input  logic sdis_in,
    input  logic uv_flag,
    input  logic hot_flag,
    input  logic cool_flag,
    input  logic cold_flag,
    input  logic iload_low,
    input  logic vout_high,
    output logic gate_en,
    output logic stat_pd_en,
    output logic stat_oe
);
    logic ctl_s, sdis_s;
    logic th_off, ot_flag;
    logic olon_done, olrel_done, stk_done;
    logic ol_hold;
    logic fault_lo;

    hss_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sdis_in, ctl_in}),
        .q    ({sdis_s, ctl_s})
    );

    hss_thermal #(.OT_DLY(OT_DLY)) u_thermal (
        .clk      (clk),
        .rst_n    (rst_n),
        .hot      (hot_flag),
        .cool     (cool_flag),
        .cold     (cold_flag),
        .force_off(th_off),
        .ot_flag  (ot_flag)
    );

    // Output stage enable: requested, supply good, not thermally shut down.
    assign gate_en = ctl_s & ~uv_flag & ~th_off;

    hss_qual_timer #(.DLY(OLON_DLY)) u_olon_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (gate_en & iload_low),
        .done (olon_done)
    );

    hss_qual_timer #(.DLY(OLREL_DLY)) u_olrel_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (ol_hold & ~ctl_s),
        .done (olrel_done)
    );

    hss_qual_timer #(.DLY(STK_DLY)) u_stk_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .cond (~ctl_s & vout_high),
        .done (stk_done)
    );

    // Open-load report holder: set on qualified open load, cleared when load
    // current returns while on, or when the release delay after turn-off ends.
    always_ff @(posedge clk) begin
        if (!rst_n) ol_hold <= 1'b0;
        else        ol_hold <= (ol_hold | olon_done)
                               & ~olrel_done & ~(ctl_s & ~iload_low);
    end

    // Truth-table merge: overtemperature shows only with control high.
    assign fault_lo   = (ot_flag & ctl_s) | ol_hold | stk_done;
    assign stat_pd_en = fault_lo & ~uv_flag & ~sdis_s;
    assign stat_oe    = ~sdis_s;

    // R3: a high-impedance status line is never pulled low.
    p_hiz_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_oe |-> !stat_pd_en);

    // R10: undervoltage keeps the output off.
    p_uv_gate_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |-> !gate_en);

    // R7: with control low and no open-load or stuck report, status is released.
    p_ot_low_ctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_s && !ol_hold && !stk_done) |-> !stat_pd_en);
endmodule

// File: tb/hss_diag_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected output values with their due
// cycle; a monitor on the falling edge pops and compares them.
module hss_diag_ctrl_tb;
    localparam int D_OLON = 6;
    localparam int D_REL  = 5;
    localparam int D_STK  = 7;
    localparam int D_OT   = 4;
    localparam int S_GATE = 0;
    localparam int S_PD   = 1;
    localparam int S_OE   = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic ctl_in, sdis_in, uv_flag, hot_flag, cool_flag, cold_flag;
    logic iload_low, vout_high;
    logic gate_en, stat_pd_en, stat_oe;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    int    q_due[$];
    int    q_sig[$];
    bit    q_val[$];
    string q_req[$];

    always #5 clk = ~clk;

    hss_diag_ctrl #(
        .OLON_DLY (D_OLON),
        .OLREL_DLY(D_REL),
        .STK_DLY  (D_STK),
        .OT_DLY   (D_OT)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_in    (ctl_in),
        .sdis_in   (sdis_in),
        .uv_flag   (uv_flag),
        .hot_flag  (hot_flag),
        .cool_flag (cool_flag),
        .cold_flag (cold_flag),
        .iload_low (iload_low),
        .vout_high (vout_high),
        .gate_en   (gate_en),
        .stat_pd_en(stat_pd_en),
        .stat_oe   (stat_oe)
    );

    // Queue an expectation dly falling edges from now.
    task automatic expect_at(input int dly, input int sig, input bit val, input string req);
        q_due.push_back(cyc + dly);
        q_sig.push_back(sig);
        q_val.push_back(val);
        q_req.push_back(req);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Monitor: compare every expectation due on this falling edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = q_due.size() - 1; i >= 0; i--) begin
            if (q_due[i] == cyc) begin
                logic act;
                string nm;
                case (q_sig[i])
                    S_GATE:  begin act = gate_en;    nm = "gate_en";    end
                    S_PD:    begin act = stat_pd_en; nm = "stat_pd_en"; end
                    default: begin act = stat_oe;    nm = "stat_oe";    end
                endcase
                checks++;
                if (act !== q_val[i]) begin
                    errors++;
                    $display("FAIL %s cycle %0d %s actual %b expected %b",
                             q_req[i], cyc, nm, act, q_val[i]);
                end
                q_due.delete(i);
                q_sig.delete(i);
                q_val.delete(i);
                q_req.delete(i);
            end
        end
    end

    initial begin
        ctl_in = 0; sdis_in = 0; uv_flag = 0; hot_flag = 0;
        cool_flag = 1; cold_flag = 1; iload_low = 0; vout_high = 0;
        rst_n = 0;
        tick(2);
        // R1: reset state
        expect_at(1, S_GATE, 0, "R1");
        expect_at(1, S_PD,   0, "R1");
        expect_at(1, S_OE,   1, "R1");
        tick(2);
        rst_n = 1;
        expect_at(1, S_GATE, 0, "R1");
        expect_at(1, S_PD,   0, "R1");
        expect_at(1, S_OE,   1, "R1");
        tick(3);

        // R2: normal on/off with sync latency
        ctl_in = 1;
        expect_at(1, S_GATE, 0, "R2");
        expect_at(2, S_GATE, 1, "R2");
        expect_at(2, S_PD,   0, "R2");
        tick(4);
        ctl_in = 0;
        expect_at(1, S_GATE, 1, "R2");
        expect_at(2, S_GATE, 0, "R2");
        expect_at(2, S_PD,   0, "R2");
        tick(4);

        // R4: glitch shorter than the delay is not reported
        ctl_in = 1;
        tick(4);
        iload_low = 1;
        tick(D_OLON - 1);
        iload_low = 0;
        expect_at(2, S_PD, 0, "R4");
        expect_at(3, S_PD, 0, "R4");
        tick(4);
        // R4: full open-load run
        iload_low = 1;
        expect_at(D_OLON,     S_PD, 0, "R4");
        expect_at(D_OLON + 1, S_PD, 1, "R4");
        tick(D_OLON + 3);
        // R5: release delay after turn-off
        ctl_in = 0;
        expect_at(2,         S_PD, 1, "R5");
        expect_at(2 + D_REL, S_PD, 1, "R5");
        expect_at(3 + D_REL, S_PD, 0, "R5");
        tick(D_REL + 6);
        iload_low = 0;
        tick(2);

        // R6: output stuck high with control low
        vout_high = 1;
        expect_at(D_STK - 1, S_PD, 0, "R6");
        expect_at(D_STK,     S_PD, 1, "R6");
        tick(D_STK + 2);
        // R3: disable hides the active fault
        sdis_in = 1;
        expect_at(1, S_OE, 1, "R3");
        expect_at(2, S_OE, 0, "R3");
        expect_at(2, S_PD, 0, "R3");
        tick(4);
        sdis_in = 0;
        expect_at(2, S_OE, 1, "R3");
        expect_at(2, S_PD, 1, "R3");
        tick(4);
        vout_high = 0;
        expect_at(1, S_PD, 0, "R6");
        tick(3);
        // R6: high output voltage with control high is not reported
        ctl_in = 1;
        tick(4);
        vout_high = 1;
        expect_at(D_STK + 2, S_PD, 0, "R6");
        tick(D_STK + 4);
        vout_high = 0;
        tick(1);

        // R7: overtemperature
        hot_flag = 1; cool_flag = 0; cold_flag = 0;
        expect_at(1,        S_GATE, 0, "R7");
        expect_at(D_OT,     S_PD,   0, "R7");
        expect_at(D_OT + 1, S_PD,   1, "R7");
        tick(D_OT + 3);
        ctl_in = 0;
        expect_at(1, S_PD, 1, "R7");
        expect_at(2, S_PD, 0, "R7");
        tick(4);
        ctl_in = 1;
        expect_at(2, S_PD,   1, "R7");
        expect_at(2, S_GATE, 0, "R7");
        tick(4);

        // R8: restart and thermal cycling
        hot_flag = 0; cool_flag = 1;
        expect_at(1, S_GATE, 1, "R8");
        expect_at(1, S_PD,   1, "R8");
        tick(3);
        hot_flag = 1; cool_flag = 0;
        expect_at(1, S_GATE, 0, "R8");
        expect_at(1, S_PD,   1, "R8");
        tick(3);
        hot_flag = 0; cool_flag = 1;
        expect_at(1, S_GATE, 1, "R8");
        expect_at(3, S_PD,   1, "R8");
        tick(4);

        // R9: clear on the lower threshold
        cold_flag = 1;
        expect_at(1, S_PD,   0, "R9");
        expect_at(1, S_GATE, 1, "R9");
        tick(3);

        // R10: undervoltage
        uv_flag = 1;
        expect_at(1, S_GATE, 0, "R10");
        expect_at(1, S_PD,   0, "R10");
        tick(3);
        uv_flag = 0;
        expect_at(1, S_GATE, 1, "R10");
        tick(4);

        if (q_due.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d expectations unconsumed, expected 0", q_due.size());
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule